// File: doc/BRIEF.md
# Byte-Wide Flash Programming Controller

This block drives byte writes into an on-chip flash program memory from a parallel programming interface. An external programmer places a 12-bit address on two ports. The low byte goes on one port and the upper four bits on another. Write data goes on a third port, and an operation code goes on a two-bit select port. The programmer then sends one active-low pulse on the program strobe. When the strobe returns high, the block starts a self-timed write. The write lasts a fixed number of clock cycles, and `busy` is high for that whole time.

While a write is in flight, the programmer can poll for completion by reading back the address being written. The most significant bit of the returned byte is inverted until the cycle finishes. After that, the true stored byte is returned. The same read path also serves verify reads of the array and three fixed signature bytes. The third signature byte reads FFh, which tells the programmer that the part expects the 12 V programming supply.

The array is a 4096 x 8 register model. It is erased to FFh at reset. A lock-bit write takes one strobe and one full timed cycle, but it leaves the array unchanged.

Sequencer states:
- `ST_IDLE`: no write in flight.
- `ST_PROG`: a timed write is counting down.

Transitions:
- `ST_IDLE` to `ST_PROG`: an accepted strobe rising edge.
- `ST_PROG` to `ST_PROG`: the countdown is above zero. A strobe that arrives in this state only raises the error flag.
- `ST_PROG` to `ST_IDLE`: the countdown reaches zero. On that edge the byte is committed.

Top module: `flash_pgm_ctrl`

## Requirements
- R1: After reset, `busy` and `err` are 0 and every array location reads FFh in verify mode.
- R2: Programming mode is active only while `rst_hold` is 1 and `pse_n` is 0. Outside it, `data_oe` is 0 and strobes start nothing.
- R3: The array address is `{addr_hi[3:0], addr_lo[7:0]}`, which covers 000h to FFFh.
- R4: `mode_sel` encodes the operation as follows:
  - 2'b00: byte write.
  - 2'b01: verify read.
  - 2'b10: lock-bit write.
  - 2'b11: signature read.
  
  In programming mode `data_oe` is 1 exactly for codes 01 and 11. A strobe under a read code starts nothing.
- R5: A write starts at the first clock edge that samples `prog_n` high after it was sampled low. `busy` is then 1 for exactly WRITE_CYCLES consecutive cycles.
- R6: The address and data present at that edge are the ones written. Once `busy` falls, a verify read of that address returns the written byte.
- R7: While `busy` is 1, a verify read of the address being written returns the written byte with bit 7 inverted. A verify read of any other address returns its current stored contents.
- R8: A strobe edge while `busy` is 1 is ignored: the running write keeps its timing and its data. It sets `err`, which stays 1 until reset.
- R9: A lock-bit write keeps `busy` high for WRITE_CYCLES cycles and leaves the array contents unchanged.
- R10: In signature mode, the addresses return the following bytes:
  - 030h: SIG_0 (default 1Eh).
  - 031h: SIG_1 (default 51h).
  - 032h: SIG_2 (default FFh, meaning the 12 V supply).
  - Any other 12-bit address: 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; erases the array and clears state |
| addr_lo | input | 8 | Low byte of the array address |
| addr_hi | input | 4 | Upper address bits |
| data_in | input | 8 | Byte to be written |
| data_out | output | 8 | Read data (verify, polling or signature) |
| data_oe | output | 1 | High when `data_out` should drive the shared data pins |
| mode_sel | input | 2 | Operation code (see R4) |
| rst_hold | input | 1 | Must be high in programming mode |
| pse_n | input | 1 | Must be low in programming mode |
| prog_n | input | 1 | Active-low program strobe |
| busy | output | 1 | Timed write in progress |
| err | output | 1 | Sticky flag: a strobe arrived while busy |

## Verification
The hardest situation to reach from the ports is a second strobe that lands inside a running write. The same is true of a polling read that happens before the commit edge. The bench creates both cases by releasing the strobe and then, at the very next falling clock edge, pulsing it again or switching to a verify read of the pending address. The busy cycle count is then checked to confirm that the first write kept its timing. The bench also checks that the committed byte is the first one and not the one that came with the ignored strobe. A full write-then-read sweep of all 4096 addresses, using an arithmetic data pattern, shows that every address bit reaches the array.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'b00,
        OP_VERIFY = 2'b01,
        OP_LOCK   = 2'b10,
        OP_SIG    = 2'b11
    } fpc_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PROG = 1'b1
    } fpc_state_e;

endpackage

// File: rtl/fpc_strobe_edge.sv
module fpc_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic rise
);

    logic strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b1;
        else        strobe_q <= strobe_n;
    end

    // low sampled last cycle, high now: the strobe has just ended
    assign rise = strobe_n & ~strobe_q;

endmodule

// File: rtl/fpc_write_fsm.sv
module fpc_write_fsm
    import fpc_pkg::*;
#(
    parameter int WRITE_CYCLES = 16,
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  fpc_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              err,
    output logic              commit_en,
    output logic              pend_valid,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [DATA_W-1:0] pend_data
);

    localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRITE_CYCLES - 1);

    fpc_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             pend_lock;
    logic             accept;

    assign accept = strobe && ((op == OP_WRITE) || (op == OP_LOCK));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)      state_nx = ST_PROG;
            ST_PROG: if (cnt == '0)   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            pend_addr <= '0;
            pend_data <= '0;
            pend_lock <= 1'b0;
            err       <= 1'b0;
        end else begin
            if (state == ST_IDLE && accept) begin
                cnt       <= CNT_LAST;
                pend_addr <= addr;
                pend_data <= wdata;
                pend_lock <= (op == OP_LOCK);
            end else if (state == ST_PROG && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (state == ST_PROG && accept) err <= 1'b1;
        end
    end

    always_comb begin
        busy       = (state == ST_PROG);
        pend_valid = busy && !pend_lock;
        commit_en  = busy && (cnt == '0) && !pend_lock;
    end

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(accept));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(busy));

    // R6
    commit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> !busy);

    // R8
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(pend_data) && $stable(pend_addr)));

endmodule

// File: rtl/fpc_cell_array.sv
module fpc_cell_array #(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  SIG_0    = 8'h1E,
    parameter logic [7:0]  SIG_1    = 8'h51,
    parameter logic [7:0]  SIG_2    = 8'hFF,
    parameter int          SIG_BASE = 'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_sig,
    input  logic              poll_valid,
    input  logic [ADDR_W-1:0] poll_addr,
    input  logic [DATA_W-1:0] poll_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int N_SIG = 3;
    localparam logic [DATA_W-1:0] ERASED = '1;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] sig_rom [N_SIG];

    assign sig_rom[0] = DATA_W'(SIG_0);
    assign sig_rom[1] = DATA_W'(SIG_1);
    assign sig_rom[2] = DATA_W'(SIG_2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_sig) begin
            for (int s = 0; s < N_SIG; s++)
                if (rd_addr == ADDR_W'(SIG_BASE + s)) rd_data = sig_rom[s];
        end else if (poll_valid && rd_addr == poll_addr) begin
            rd_data = {~poll_data[DATA_W-1], poll_data[DATA_W-2:0]};
        end else begin
            rd_data = cells[rd_addr];
        end
    end

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cells[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/flash_pgm_ctrl.sv
module flash_pgm_ctrl
    import fpc_pkg::*;
#(
    parameter int         WRITE_CYCLES = 16,
    parameter int         ADDR_W       = 12,
    parameter int         DATA_W       = 8,
    parameter logic [7:0] SIG_0        = 8'h1E,
    parameter logic [7:0] SIG_1        = 8'h51,
    parameter logic [7:0] SIG_2        = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          addr_lo,
    input  logic [ADDR_W-9:0]   addr_hi,
    input  logic [DATA_W-1:0]   data_in,
    output logic [DATA_W-1:0]   data_out,
    output logic                data_oe,
    input  logic [1:0]          mode_sel,
    input  logic                rst_hold,
    input  logic                pse_n,
    input  logic                prog_n,
    output logic                busy,
    output logic                err
);

    logic              pmode, rise, strobe;
    logic              commit_en, pend_valid;
    logic [ADDR_W-1:0] full_addr, pend_addr;
    logic [DATA_W-1:0] pend_data;
    fpc_op_e           op;

    assign pmode     = rst_hold & ~pse_n;
    assign full_addr = {addr_hi, addr_lo};
    assign op        = fpc_op_e'(mode_sel);
    assign strobe    = rise & pmode;
    assign data_oe   = pmode && ((op == OP_VERIFY) || (op == OP_SIG));

    fpc_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (prog_n),
        .rise     (rise)
    );

    fpc_write_fsm #(
        .WRITE_CYCLES (WRITE_CYCLES),
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .op         (op),
        .addr       (full_addr),
        .wdata      (data_in),
        .busy       (busy),
        .err        (err),
        .commit_en  (commit_en),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .pend_data  (pend_data)
    );

    fpc_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SIG_0  (SIG_0),
        .SIG_1  (SIG_1),
        .SIG_2  (SIG_2)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (commit_en),
        .wr_addr    (pend_addr),
        .wr_data    (pend_data),
        .rd_addr    (full_addr),
        .rd_sig     (op == OP_SIG),
        .poll_valid (pend_valid),
        .poll_addr  (pend_addr),
        .poll_data  (pend_data),
        .rd_data    (data_out)
    );

    // R2
    no_start_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pmode |=> !$rose(busy));

    // R7
    poll_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_VERIFY && pend_valid && full_addr == pend_addr)
            |-> (data_out[DATA_W-1] != pend_data[DATA_W-1]));

    // R4
    read_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && data_oe) |=> !busy);

endmodule

// File: tb/flash_pgm_ctrl_bench.sv
module flash_pgm_ctrl_bench;

    localparam int NCYC = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_lo = '0;
    logic [3:0] addr_hi = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;
    logic [1:0] mode_sel = 2'b01;
    logic       rst_hold = 1'b1;
    logic       pse_n = 1'b0;
    logic       prog_n = 1'b1;
    logic       busy, err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_pgm_ctrl #(.WRITE_CYCLES(NCYC)) u_flash_pgm_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .addr_hi(addr_hi),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .mode_sel(mode_sel), .rst_hold(rst_hold), .pse_n(pse_n),
        .prog_n(prog_n), .busy(busy), .err(err)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + (a >> 5)) ^ 8'hA5);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic set_addr(input int a);
        addr_lo = 8'(a);
        addr_hi = 4'(a >> 8);
    endtask

    // read at a fresh falling edge; result is combinational
    task automatic rd(input logic [1:0] op, input int a, output int d, output int oe);
        @(negedge clk);
        mode_sel = op;
        set_addr(a);
        #1;
        d  = data_out;
        oe = data_oe;
    endtask

    // strobe low for one cycle, released at a falling edge
    task automatic strobe(input logic [1:0] op, input int a, input int d);
        @(negedge clk);
        mode_sel = op;
        set_addr(a);
        data_in = 8'(d);
        prog_n  = 1'b0;
        @(negedge clk);
        prog_n  = 1'b1;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            #1;
            if (busy) n++;
            else break;
        end
    endtask

    initial begin
        int d, oe, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 err", err, 0);
        for (int a = 0; a < 4096; a++) begin
            rd(2'b01, a, d, oe);
            if (d != 8'hFF) check("R1 erased", d, 8'hFF);
        end
        check("R1 erased sweep done", 1, 1);

        // R4 output enable per code
        rd(2'b01, 0, d, oe); check("R4 oe verify", oe, 1);
        rd(2'b11, 0, d, oe); check("R4 oe sig", oe, 1);
        rd(2'b00, 0, d, oe); check("R4 oe write", oe, 0);
        rd(2'b10, 0, d, oe); check("R4 oe lock", oe, 0);
        strobe(2'b01, 5, 8'h00);
        count_busy(n);
        check("R4 read strobe no busy", n, 0);

        // R3 R5 R6 full sweep
        for (int a = 0; a < 4096; a++) begin
            strobe(2'b00, a, pat(a));
            count_busy(n);
            if (n != NCYC) check("R5 busy length", n, NCYC);
        end
        check("R5 sweep done", 1, 1);
        for (int a = 0; a < 4096; a++) begin
            rd(2'b01, a, d, oe);
            if (d != pat(a)) check("R3 R6 readback", d, pat(a));
        end
        check("R3 readback sweep done", 1, 1);

        // R7 polling
        strobe(2'b00, 12'h123, 8'h3C);
        rd(2'b01, 12'h123, d, oe);
        check("R7 busy during poll", busy, 1);
        check("R7 poll inverted msb", d, 8'hBC);
        rd(2'b01, 12'h124, d, oe);
        check("R7 other address", d, pat(12'h124));
        count_busy(n);
        rd(2'b01, 12'h123, d, oe);
        check("R7 true after done", d, 8'h3C);
        strobe(2'b00, 12'hABC, 8'hC5);
        rd(2'b01, 12'hABC, d, oe);
        check("R7 poll msb set", d, 8'h45);
        count_busy(n);
        rd(2'b01, 12'hABC, d, oe);
        check("R6 after poll", d, 8'hC5);

        // R9 lock write
        strobe(2'b10, 12'h200, 8'h00);
        count_busy(n);
        check("R9 lock busy length", n, NCYC);
        rd(2'b01, 12'h200, d, oe);
        check("R9 array unchanged", d, pat(12'h200));

        // R10 signature
        rd(2'b11, 12'h030, d, oe); check("R10 sig0", d, 8'h1E);
        rd(2'b11, 12'h031, d, oe); check("R10 sig1", d, 8'h51);
        rd(2'b11, 12'h032, d, oe); check("R10 sig2 12V", d, 8'hFF);
        rd(2'b11, 12'h033, d, oe); check("R10 other", d, 0);
        rd(2'b11, 12'h02F, d, oe); check("R10 other low", d, 0);
        rd(2'b11, 12'h130, d, oe); check("R10 high bits", d, 0);

        // R2 outside programming mode
        @(negedge clk);
        rst_hold = 1'b0;
        rd(2'b01, 12'h010, d, oe); check("R2 oe off", oe, 0);
        strobe(2'b00, 12'h010, 8'h11);
        count_busy(n);
        check("R2 no busy", n, 0);
        @(negedge clk);
        rst_hold = 1'b1;
        pse_n = 1'b1;
        strobe(2'b00, 12'h010, 8'h22);
        count_busy(n);
        check("R2 pse high no busy", n, 0);
        pse_n = 1'b0;
        rd(2'b01, 12'h010, d, oe);
        check("R2 array unchanged", d, pat(12'h010));

        // R8 strobe during busy
        check("R8 err before", err, 0);
        strobe(2'b00, 12'h300, 8'h5A);
        n = 1;  // busy already high after release edge
        @(negedge clk);
        mode_sel = 2'b00; set_addr(12'h301); data_in = 8'h77; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1;
        n = 2;
        begin
            int m;
            count_busy(m);
            check("R8 timing kept", n + m, NCYC);
        end
        check("R8 err set", err, 1);
        rd(2'b01, 12'h300, d, oe); check("R8 first data kept", d, 8'h5A);
        rd(2'b01, 12'h301, d, oe); check("R8 second ignored", d, pat(12'h301));
        repeat (3) @(negedge clk);
        #1;
        check("R8 err sticky", err, 1);

        // R1 reset clears error
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'b01, 12'h300, d, oe);
        check("R1 err cleared", err, 0);
        check("R1 erased after reset", d, 8'hFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog act=timeout exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule